// File: doc/BRIEF.md
# Instruction Cache Way Parity Scrubber

This block inspects one way of an instruction-cache set after a cache error and reports which parity classes are broken. A request carries the tag-high and tag-low words that were read for the way, together with the way number and the set index. If the request also asks for a data check, the block steps through the four data beats of the line. For each beat it presents the read address of that beat. The caller returns the beat's side word (predecode byte, predecode parity and per-byte instruction parities) and its two instructions.

When the check ends, the block raises `done` for one cycle. The error flags hold their values until the next request is accepted. They report tag parity (valid-bit copy, low tag field, high tag field), data parity (predecode, instruction A, instruction B), a per-beat fault vector and the oldest and newest way from the replacement-order field. Error handling software uses the flags to confirm or reject the error class that the hardware logged.

Top module: `ic_parity_scrubber`

## Requirements
- R1: Tag-high bit 29 is the valid bit and bit 27 its stored copy. Any mismatch sets `vpar_err` and `tag_err`, whether the entry is valid or not.
- R2: For a valid entry, tag-low bit 10 must equal the XOR of tag-low bits 23:0 with bits 11 and 10 left out. A mismatch sets `tag_low_err` and `tag_err`.
- R3: For a valid entry, tag-low bit 11 must equal the XOR of tag-low bits 63:24. A mismatch sets `tag_high_err` and `tag_err`. An invalid entry never sets `tag_low_err` or `tag_high_err`.
- R4: In each beat's 17-bit side word, bits 15:8 hold the predecode byte and bit 16 its parity. A mismatch sets `predecode_err` and `data_err`.
- R5: Side-word bits 7:4 hold the byte parities of instruction A and bits 3:0 those of instruction B. Nibble bit 3 covers instruction bits 31:24 and nibble bit 0 covers bits 7:0. A mismatch sets `insn_a_err` or `insn_b_err`, and `data_err`.
- R6: While beat k (0 to 3) is awaited, `beat_addr` is {way, index AND 0x1fe0, with k placed in bits 4:3}. The way sits in bits 14:13 and bits 2:0 are zero.
- R7: `lru_oldest` shows tag-high bits 15:14 and `lru_newest` shows tag-high bits 21:20 of the accepted request.
- R8: Data error flags are sticky over the four beats. `beat_err[k]` is set when beat k has any data fault. All flags are replaced or cleared when a new request is accepted.
- R9: `req_ready` is high only when the block is idle and `beat_ready` only while it awaits a beat. A beat offered while idle is ignored. `done` is a single-cycle pulse in the cycle after the last beat is taken, or after acceptance when no data check is asked.
- R10: After reset, `req_ready` is 1 and `beat_ready`, `done` and all error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Check request offered |
| req_ready | output | 1 | Block can accept a request |
| req_check_data | input | 1 | Also check the four data beats |
| req_way | input | 2 | Way under inspection |
| req_index | input | 13 | Set index address bits |
| req_tag_hi | input | 32 | Tag-high word |
| req_tag_lo | input | 64 | Tag-low word |
| beat_valid | input | 1 | Data beat offered |
| beat_ready | output | 1 | Block awaits a data beat |
| beat_addr | output | 15 | Read address of the awaited beat |
| beat_side | input | 17 | Predecode byte, its parity, instruction byte parities |
| beat_insn_a | input | 32 | First instruction of the beat |
| beat_insn_b | input | 32 | Second instruction of the beat |
| done | output | 1 | One-cycle completion pulse |
| tag_err | output | 1 | Any tag parity fault |
| data_err | output | 1 | Any data parity fault |
| vpar_err | output | 1 | Valid-bit copy mismatch |
| tag_low_err | output | 1 | Low tag field parity fault |
| tag_high_err | output | 1 | High tag field parity fault |
| predecode_err | output | 1 | Predecode parity fault in some beat |
| insn_a_err | output | 1 | Instruction A byte parity fault in some beat |
| insn_b_err | output | 1 | Instruction B byte parity fault in some beat |
| beat_err | output | 4 | Per-beat data fault vector |
| lru_oldest | output | 2 | Least recently used way |
| lru_newest | output | 2 | Most recently used way |

## Verification
The bench sets only tag-low bit 11 or only bit 10 on a valid entry. A design that left the stored bits inside the low coverage would report both fields. An invalid entry with a broken valid-bit copy and random tag words must show the valid-copy error alone; a design that gated that check by validity, or ran the field checks on dead entries, would show the wrong set. Random beats with single flipped parity bits catch reversed nibble byte order and swapped A/B nibbles. Beats offered while idle, and a fault in an early beat followed by clean beats, expose a design that takes stray beats or loses sticky state.

// File: rtl/ic_scrub_pkg.sv
package ic_scrub_pkg;
  // tag-high positions
  localparam int unsigned VBIT_POS   = 29;
  localparam int unsigned VCOPY_POS  = 27;
  localparam int unsigned LRU_LSB    = 14;
  // tag-low positions
  localparam int unsigned LOWPAR_POS = 10;
  localparam int unsigned HIPAR_POS  = 11;
  localparam int unsigned SPLIT_POS  = 24;

  typedef struct packed {
    logic high_fld;
    logic low_fld;
    logic vcopy;
  } tag_fault_t;

  typedef struct packed {
    logic pre;
    logic ia;
    logic ib;
  } beat_fault_t;
endpackage

// File: rtl/scrub_tag_chk.sv
module scrub_tag_chk
  import ic_scrub_pkg::*;
(
  input  logic [31:0] tag_hi,
  input  logic [63:0] tag_lo,
  output tag_fault_t  fault
);
  logic              vld;
  logic [SPLIT_POS-1:0] low_cov;

  always_comb begin
    vld     = tag_hi[VBIT_POS];
    low_cov = tag_lo[SPLIT_POS-1:0];
    low_cov[LOWPAR_POS] = 1'b0;
    low_cov[HIPAR_POS]  = 1'b0;
    fault.vcopy    = vld ^ tag_hi[VCOPY_POS];
    fault.low_fld  = vld & (tag_lo[LOWPAR_POS] ^ (^low_cov));
    fault.high_fld = vld & (tag_lo[HIPAR_POS] ^ (^tag_lo[63:SPLIT_POS]));
  end

  logic unused_hi;
  assign unused_hi = ^{tag_hi[31:30], tag_hi[28], tag_hi[26:0]};
endmodule

// File: rtl/scrub_beat_chk.sv
module scrub_beat_chk
  import ic_scrub_pkg::*;
#(
  parameter int unsigned INSN_W = 32,
  localparam int unsigned NBYTE  = INSN_W / 8,
  localparam int unsigned SIDE_W = 9 + 2 * NBYTE
) (
  input  logic [SIDE_W-1:0] side,
  input  logic [INSN_W-1:0] insn_a,
  input  logic [INSN_W-1:0] insn_b,
  output beat_fault_t       fault
);
  logic [NBYTE-1:0] nib_a, nib_b;

  // nibble bit k covers instruction byte k (top byte -> top bit)
  for (genvar k = 0; k < NBYTE; k++) begin : g_byte
    assign nib_a[k] = ^insn_a[8*k +: 8];
    assign nib_b[k] = ^insn_b[8*k +: 8];
  end

  always_comb begin
    fault.pre = side[SIDE_W-1] ^ (^side[2*NBYTE +: 8]);
    fault.ia  = side[NBYTE +: NBYTE] != nib_a;
    fault.ib  = side[0 +: NBYTE] != nib_b;
  end
endmodule

// File: rtl/scrub_ctrl.sv
module scrub_ctrl #(
  parameter int unsigned BEATS = 4,
  localparam int unsigned BEAT_W = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_check_data,
  input  logic              beat_valid,
  output logic              req_ready,
  output logic              accept,
  output logic              beat_ready,
  output logic              take,
  output logic [BEAT_W-1:0] beat_idx,
  output logic              done
);
  typedef enum logic {ST_IDLE, ST_BEAT} st_t;
  st_t st_q, st_d;
  logic [BEAT_W-1:0] cnt_q, cnt_d;
  logic done_d, last;

  assign req_ready  = (st_q == ST_IDLE);
  assign beat_ready = (st_q == ST_BEAT);
  assign accept     = req_valid & req_ready;
  assign take       = beat_valid & beat_ready;
  assign last       = (cnt_q == BEAT_W'(BEATS - 1));
  assign beat_idx   = cnt_q;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (accept) begin
      cnt_d  = '0;
      st_d   = req_check_data ? ST_BEAT : ST_IDLE;
      done_d = ~req_check_data;
    end else if (take) begin
      cnt_d = cnt_q + 1'b1;
      if (last) begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      done  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      done  <= done_d;
    end
  end
endmodule

// File: rtl/ic_parity_scrubber.sv
module ic_parity_scrubber
  import ic_scrub_pkg::*;
#(
  parameter int unsigned WAYS     = 4,
  parameter int unsigned BEATS    = 4,
  parameter int unsigned INSN_W   = 32,
  parameter int unsigned IDX_W    = 13,
  parameter logic [12:0] SET_MASK = 13'h1fe0,
  localparam int unsigned WAY_W  = $clog2(WAYS),
  localparam int unsigned BEAT_W = $clog2(BEATS),
  localparam int unsigned SIDE_W = 9 + 2 * (INSN_W / 8),
  localparam int unsigned OFF_LSB = $clog2(2 * INSN_W / 8),
  localparam int unsigned ADDR_W = IDX_W + WAY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_check_data,
  input  logic [WAY_W-1:0]  req_way,
  input  logic [IDX_W-1:0]  req_index,
  input  logic [31:0]       req_tag_hi,
  input  logic [63:0]       req_tag_lo,
  input  logic              beat_valid,
  output logic              beat_ready,
  output logic [ADDR_W-1:0] beat_addr,
  input  logic [SIDE_W-1:0] beat_side,
  input  logic [INSN_W-1:0] beat_insn_a,
  input  logic [INSN_W-1:0] beat_insn_b,
  output logic              done,
  output logic              tag_err,
  output logic              data_err,
  output logic              vpar_err,
  output logic              tag_low_err,
  output logic              tag_high_err,
  output logic              predecode_err,
  output logic              insn_a_err,
  output logic              insn_b_err,
  output logic [BEATS-1:0]  beat_err,
  output logic [WAY_W-1:0]  lru_oldest,
  output logic [WAY_W-1:0]  lru_newest
);
  logic              accept, take;
  logic [BEAT_W-1:0] beat_idx;
  tag_fault_t        tag_f, tagf_q, tagf_d;
  beat_fault_t       bt_f, dat_q, dat_d;
  logic [BEATS-1:0]  berr_q, berr_d;
  logic [WAY_W-1:0]  way_q, way_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [WAY_W-1:0]  old_q, old_d, new_q, new_d;
  logic [IDX_W-1:0]  beat_off;

  scrub_ctrl #(.BEATS(BEATS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .req_check_data(req_check_data), .beat_valid(beat_valid),
    .req_ready(req_ready), .accept(accept), .beat_ready(beat_ready),
    .take(take), .beat_idx(beat_idx), .done(done)
  );

  scrub_tag_chk u_tag (
    .tag_hi(req_tag_hi), .tag_lo(req_tag_lo), .fault(tag_f)
  );

  scrub_beat_chk #(.INSN_W(INSN_W)) u_beat (
    .side(beat_side), .insn_a(beat_insn_a), .insn_b(beat_insn_b),
    .fault(bt_f)
  );

  always_comb begin
    tagf_d = tagf_q;
    dat_d  = dat_q;
    berr_d = berr_q;
    way_d  = way_q;
    idx_d  = idx_q;
    old_d  = old_q;
    new_d  = new_q;
    if (accept) begin
      tagf_d = tag_f;
      dat_d  = '0;
      berr_d = '0;
      way_d  = req_way;
      idx_d  = req_index;
      old_d  = req_tag_hi[LRU_LSB +: WAY_W];
      new_d  = req_tag_hi[LRU_LSB + (WAYS - 1) * WAY_W +: WAY_W];
    end else if (take) begin
      dat_d            = dat_q | bt_f;
      berr_d[beat_idx] = |bt_f;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tagf_q <= '0;
      dat_q  <= '0;
      berr_q <= '0;
      way_q  <= '0;
      idx_q  <= '0;
      old_q  <= '0;
      new_q  <= '0;
    end else if (accept | take) begin
      tagf_q <= tagf_d;
      dat_q  <= dat_d;
      berr_q <= berr_d;
      way_q  <= way_d;
      idx_q  <= idx_d;
      old_q  <= old_d;
      new_q  <= new_d;
    end
  end

  assign beat_off      = IDX_W'(beat_idx) << OFF_LSB;
  assign beat_addr     = {way_q, (idx_q & SET_MASK) | beat_off};
  assign vpar_err      = tagf_q.vcopy;
  assign tag_low_err   = tagf_q.low_fld;
  assign tag_high_err  = tagf_q.high_fld;
  assign tag_err       = |tagf_q;
  assign predecode_err = dat_q.pre;
  assign insn_a_err    = dat_q.ia;
  assign insn_b_err    = dat_q.ib;
  assign data_err      = |dat_q;
  assign beat_err      = berr_q;
  assign lru_oldest    = old_q;
  assign lru_newest    = new_q;
endmodule

// File: rtl/ic_scrub_chk.sv
module ic_scrub_chk #(
  parameter int unsigned BEATS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [31:0]      req_tag_hi,
  input logic             beat_ready,
  input logic             done,
  input logic             data_err,
  input logic             vpar_err,
  input logic             tag_low_err,
  input logic             tag_high_err,
  input logic [BEATS-1:0] beat_err
);
  logic acc;
  assign acc = req_valid && req_ready;

  logic unused_hi;
  assign unused_hi = ^{req_tag_hi[31:30], req_tag_hi[28], req_tag_hi[26:0]};

  // R9: request side and beat side never open together
  a_r9_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && beat_ready));

  // R9: done lasts one cycle unless a new quick request follows
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !acc) |=> !done);

  // R8: acceptance clears data state
  a_r8_clear_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (beat_err == '0 && !data_err));

  // R8: data error stays until next acceptance
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (data_err && !acc) |=> data_err);

  // R1: valid copy compared for every entry
  a_r1_vcopy: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (vpar_err == ($past(req_tag_hi[29]) != $past(req_tag_hi[27]))));

  // R3: invalid entries raise no field faults
  a_r3_invalid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_tag_hi[29]) |=> (!tag_low_err && !tag_high_err));
endmodule

bind ic_parity_scrubber ic_scrub_chk #(.BEATS(BEATS)) u_chk (.*);

// File: tb/ic_parity_scrubber_tb.sv
module ic_parity_scrubber_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 0, req_check_data = 0;
  logic        req_ready;
  logic [1:0]  req_way = 0;
  logic [12:0] req_index = 0;
  logic [31:0] req_tag_hi = 0;
  logic [63:0] req_tag_lo = 0;
  logic        beat_valid = 0, beat_ready;
  logic [14:0] beat_addr;
  logic [16:0] beat_side = 0;
  logic [31:0] beat_insn_a = 0, beat_insn_b = 0;
  logic done, tag_err, data_err, vpar_err, tag_low_err, tag_high_err;
  logic predecode_err, insn_a_err, insn_b_err;
  logic [3:0] beat_err;
  logic [1:0] lru_oldest, lru_newest;

  ic_parity_scrubber dut_i (.*);

  int n_chk = 0, n_bad = 0;
  logic [16:0] b_side[4];
  logic [31:0] b_a[4], b_b[4];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] nib(input logic [31:0] x);
    return {^x[31:24], ^x[23:16], ^x[15:8], ^x[7:0]};
  endfunction

  // {high field, low field, valid copy}
  function automatic logic [2:0] exp_tag(input logic [31:0] hi, input logic [63:0] lo);
    logic v;
    v = hi[29];
    return {v & (lo[11] ^ (^lo[63:24])),
            v & (lo[10] ^ (^(lo[23:0] & 24'hfff3ff))),
            hi[29] ^ hi[27]};
  endfunction

  function automatic logic [16:0] good_side(input logic [7:0] pre, input logic [31:0] a,
                                            input logic [31:0] b);
    return {^pre, pre, nib(a), nib(b)};
  endfunction

  // called just after a negedge while idle; returns just after a negedge
  task automatic run_req(input logic [31:0] hi, input logic [63:0] lo, input logic [1:0] way,
                         input logic [12:0] idx, input bit dodata);
    logic [2:0] et;
    logic pe, ae, be;
    logic [3:0] eb;
    chk("R9 req_ready idle", req_ready, 1);
    req_valid = 1; req_check_data = dodata; req_way = way; req_index = idx;
    req_tag_hi = hi; req_tag_lo = lo;
    @(negedge clk);
    req_valid = 0; req_tag_hi = $urandom; req_tag_lo = {$urandom, $urandom};
    pe = 0; ae = 0; be = 0; eb = 0;
    if (dodata) begin
      for (int k = 0; k < 4; k++) begin
        chk("R9 beat_ready", beat_ready, 1);
        chk("R6 beat_addr", beat_addr, {way, (idx & 13'h1fe0) | 13'(k << 3)});
        chk("R9 no early done", done, 0);
        beat_valid = 1; beat_side = b_side[k]; beat_insn_a = b_a[k]; beat_insn_b = b_b[k];
        begin
          logic p, a, b;
          p = b_side[k][16] ^ (^b_side[k][15:8]);
          a = b_side[k][7:4] != nib(b_a[k]);
          b = b_side[k][3:0] != nib(b_b[k]);
          pe |= p; ae |= a; be |= b; eb[k] = p | a | b;
        end
        @(negedge clk);
      end
      beat_valid = 0;
    end
    et = exp_tag(hi, lo);
    chk("R9 done pulse", done, 1);
    chk("R1 vpar_err", vpar_err, et[0]);
    chk("R2 tag_low_err", tag_low_err, et[1]);
    chk("R3 tag_high_err", tag_high_err, et[2]);
    chk("R1 tag_err", tag_err, |et);
    chk("R4 predecode_err", predecode_err, pe);
    chk("R5 insn_a_err", insn_a_err, ae);
    chk("R5 insn_b_err", insn_b_err, be);
    chk("R4 data_err", data_err, pe | ae | be);
    chk("R8 beat_err", beat_err, eb);
    chk("R7 lru_oldest", lru_oldest, hi[15:14]);
    chk("R7 lru_newest", lru_newest, hi[21:20]);
    @(negedge clk);
    chk("R9 done single", done, 0);
  endtask

  task automatic fill_beats(input int flip_pct);
    for (int k = 0; k < 4; k++) begin
      b_a[k] = $urandom; b_b[k] = $urandom;
      b_side[k] = good_side(8'($urandom), b_a[k], b_b[k]);
      if (($urandom % 100) < flip_pct) b_side[k][$urandom % 17] ^= 1'b1;
    end
  endtask

  initial begin
    void'($urandom(32'h5c4b_0917));
    repeat (3) @(negedge clk);
    chk("R10 req_ready", req_ready, 1);
    chk("R10 beat_ready", beat_ready, 0);
    chk("R10 done", done, 0);
    chk("R10 flags", {tag_err, data_err, beat_err}, 0);
    rst_n = 1;
    @(negedge clk);

    // R3/R2 coverage split: only bit 11 set on a valid entry
    run_req(32'h2800_0000, 64'h800, 2'd1, 13'h0abc, 0);
    // only bit 10 set: low field fault alone
    run_req(32'h2800_0000, 64'h400, 2'd2, 13'h1fff, 0);
    // invalid entry, broken copy, garbage tag low: only R1 fault
    run_req(32'h0800_0000, 64'hdead_beef_1234_5678, 2'd0, 13'h0, 0);
    run_req(32'h0000_0000, 64'hffff_0000_ffff_0c00, 2'd3, 13'h0, 0);
    // R7 replacement order decode
    run_req(32'h2826_c000, 64'h0, 2'd0, 13'h0, 0);

    // R9 beat while idle is ignored
    beat_valid = 1; beat_side = 17'h1_0000; beat_insn_a = 32'h1; beat_insn_b = 32'h0;
    @(negedge clk);
    chk("R9 beat_ready idle", beat_ready, 0);
    beat_valid = 0;
    fill_beats(0);
    run_req(32'h2800_0000, 64'h0, 2'd2, 13'h1234, 1);

    // R8 fault in beat 0 only stays sticky
    fill_beats(0);
    b_side[0][5] ^= 1'b1;
    run_req(32'h2800_0000, 64'h0, 2'd1, 13'h0fe0, 1);
    // R5 byte-order check: top byte of A, parity nibble top bit
    fill_beats(0);
    b_a[2] = 32'h0100_0000; b_side[2] = good_side(8'h00, b_a[2], b_b[2]);
    b_side[2][4] ^= 1'b1; b_side[2][7] ^= 1'b1;
    run_req(32'h0000_0000, 64'h0, 2'd3, 13'h0020, 1);

    for (int i = 0; i < 200; i++) begin
      logic [31:0] hi; logic [63:0] lo;
      hi = $urandom; lo = {$urandom, $urandom};
      if ($urandom % 2) begin
        hi[27] = hi[29];
        lo[10] = ^(lo[23:0] & 24'hfff3ff);
        lo[11] = ^lo[63:24];
        if ($urandom % 3 == 0) lo[$urandom % 64] ^= 1'b1;
      end
      fill_beats(35);
      run_req(hi, lo, 2'($urandom), 13'($urandom), bit'($urandom % 2));
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R9 actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule